// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software reach the management registers of an external Ethernet PHY through one 32-bit register. A single write to that register carries the operation request, the PHY address, the PHY register address and, for writes, the 16-bit value. The controller then produces the management clock and runs a complete Clause 22 frame on the bidirectional data line. For a read, the 16 bits returned by the PHY replace the data field of the same register.

While a frame is in progress a busy flag is raised and further register writes are ignored. On a read, the controller checks that the PHY pulled the line low in the second turnaround bit. If it did not, a not-valid flag marks the returned data as untrustworthy. After reset, the PHY address field holds a build-time default that software can read before it writes anything.

The management clock comes from the system clock through a parameterised divider. Outgoing bits change on the falling edge of the management clock. Incoming bits are sampled on its rising edge.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, `reg_rdata` holds the default PHY address (parameter `DEF_PHY`) in bits 15:11 and zero in every other bit, and `mdc` and `mdio_oe` are low.
- R2: Register layout: bit 0 requests a write operation and bit 1 a read operation. Bits 10:6 are the PHY register address, bits 15:11 the PHY address and bits 31:16 the data. Bit 2 reads as busy and bit 3 as not-valid. Bits 1:0 and 5:4 always read as zero. A write made while idle with bits 1:0 both zero stores the address and data fields and starts nothing.
- R3: A write made while idle with bit 0 or bit 1 set starts an operation, and busy reads as 1 from the next cycle. If both bits are set, the operation is a read.
- R4: A register write made while busy has no effect on the stored fields or on the frame in progress.
- R5: `mdc` is low whenever the block is idle. During an operation it first rises `CLK_DIV` system cycles after the accepting edge and then has a period of 2*`CLK_DIV` system cycles.
- R6: The frame is 64 bits, most significant bit first, in this order: 32 ones, start bits 0 then 1, an opcode (1,0 for a read; 0,1 for a write), the 5-bit PHY address, the 5-bit register address, two turnaround bits and 16 data bits. A write drives turnaround 1,0 followed by the write data, with `mdio_oe` high for all 64 bits.
- R7: On a read, `mdio_oe` is high for the first 46 bits and low for the two turnaround bits and the 16 data bits.
- R8: On a read, the 16 data bits sampled on the rising edges of `mdc` appear in bits 31:16 after the operation ends, first-sampled bit in bit 31.
- R9: After a read, not-valid is 1 exactly when `mdio_i` was high at the rising edge of the second turnaround bit. Starting any operation clears it.
- R10: Outgoing bits change only on the falling edge of `mdc`. Busy clears at the 64th falling edge, 128*`CLK_DIV` system cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven to the line |
| mdio_oe | output | 1 | Output enable for the management data line |
| mdio_i | input | 1 | Management data sampled from the line |

## Verification
The bench decodes every frame bit by bit on the rising edges of the management clock and compares it with a frame built from the requirements. A design with a misordered field or an opcode swap would show up here. It also checks that the output enable drops exactly at the turnaround on reads. A design that kept driving there would contend with the PHY.

Reads are run with a PHY model that either answers correctly or leaves the second turnaround bit high. This exposes a not-valid flag that tests the wrong bit or is never cleared by the next operation. A request with both command bits set checks that the read takes priority. A write injected mid-frame must leave both the stored fields and the frame on the wire untouched.

Edge times of the management clock and the time busy drops are measured against the system clock. A divider that is off by one, or a frame that is one bit short or long, fails these checks.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int          CLK_DIV = 4,
  parameter logic [4:0]  DEF_PHY = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(CLK_DIV - 1);
  localparam logic [5:0] TA_FIRST = 6'd46;
  localparam logic [5:0] TA_LAST  = 6'd47;
  localparam logic [5:0] BIT_LAST = 6'd63;

  logic          busy_q, rd_q, nval_q, mdc_q;
  logic [CW-1:0] div_q;
  logic [5:0]    bit_q;
  logic [63:0]   sh_q;
  logic [15:0]   data_q;
  logic [4:0]    phy_q, reg_q;

  wire tick  = (div_q == DIV_LAST);
  wire start = reg_wr & ~busy_q & (reg_wdata[0] | reg_wdata[1]);
  wire unused_wbits = ^reg_wdata[5:2];

  assign reg_rdata = {data_q, phy_q, reg_q, 2'b00, nval_q, busy_q, 2'b00};
  assign mdc       = mdc_q;
  assign mdio_o    = sh_q[63];
  assign mdio_oe   = busy_q & (~rd_q | (bit_q < TA_FIRST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      nval_q <= 1'b0;
      mdc_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      data_q <= '0;
      phy_q  <= DEF_PHY;
      reg_q  <= '0;
    end else if (!busy_q) begin
      div_q <= '0;
      mdc_q <= 1'b0;
      if (reg_wr) begin
        data_q <= reg_wdata[31:16];
        phy_q  <= reg_wdata[15:11];
        reg_q  <= reg_wdata[10:6];
      end
      if (start) begin
        busy_q <= 1'b1;
        rd_q   <= reg_wdata[1];
        nval_q <= 1'b0;
        bit_q  <= '0;
        sh_q   <= {32'hFFFF_FFFF, 2'b01, (reg_wdata[1] ? 2'b10 : 2'b01),
                   reg_wdata[15:11], reg_wdata[10:6], 2'b10, reg_wdata[31:16]};
      end
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!mdc_q) begin
          mdc_q <= 1'b1;
          if (rd_q && bit_q == TA_LAST) nval_q <= mdio_i;
          if (rd_q && bit_q > TA_LAST)  data_q <= {data_q[14:0], mdio_i};
        end else begin
          mdc_q <= 1'b0;
          sh_q  <= {sh_q[62:0], 1'b0};
          bit_q <= bit_q + 6'd1;
          if (bit_q == BIT_LAST) busy_q <= 1'b0;
        end
      end
    end
  end

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy_q && (reg_wdata[0] || reg_wdata[1])) |=> (busy_q && bit_q == 6'd0 && !mdc_q));

  assert_hold_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(phy_q) && $stable(reg_q)));

  assert_mdc_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc_q);

  assert_bit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (bit_q == $past(bit_q) || bit_q == $past(bit_q) + 6'd1));

  assert_nval_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !nval_q);

  assert_drive_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $stable(mdio_o));
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
  localparam int         DIV  = 4;
  localparam logic [4:0] DEFP = 5'd1;
  localparam int         TCK  = 10;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, mdio_i = 1'b1;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  mdio_mgmt_ctrl #(.CLK_DIV(DIV), .DEF_PHY(DEFP)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  always #(TCK/2) clk = ~clk;

  // {cmd[1:0], phy, reg, wdata, phy response, turnaround answered}
  localparam logic [44:0] VEC [0:5] = '{
    {2'd1, 5'd1,  5'd0,  16'h1234, 16'h0000, 1'b1},
    {2'd2, 5'd3,  5'd1,  16'h0000, 16'hA5C3, 1'b1},
    {2'd2, 5'd31, 5'd31, 16'h0000, 16'hFFFF, 1'b0},
    {2'd1, 5'd0,  5'd0,  16'h0000, 16'h0000, 1'b1},
    {2'd3, 5'd21, 5'd10, 16'h5555, 16'h0001, 1'b1},
    {2'd2, 5'd16, 5'd17, 16'h0000, 16'h8000, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] v);
    @(negedge clk); reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] cmd, input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] wd, input logic [15:0] resp, input bit ta_ok,
                        input bit interfere, output logic [63:0] seen, output logic [63:0] oes,
                        output longint t_rise, output longint t_per, output longint t_dur);
    longint t0, t_prev;
    bit rd;
    rd = cmd[1];
    @(negedge clk); reg_wdata = {wd, phy, ra, 4'b0000, cmd}; reg_wr = 1'b1;
    @(posedge clk); t0 = $time;
    @(negedge clk); reg_wr = 1'b0;
    chk(reg_rdata[2] == 1'b1, "R3 busy after start", 64'(reg_rdata[2]), 64'd1);
    mdio_i = 1'b1;
    t_prev = 0; t_per = 0; t_rise = 0;
    for (int i = 0; i < 64; i++) begin
      @(posedge mdc);
      if (i == 0) t_rise = $time - t0;
      if (i == 1) t_per = $time - t_prev;
      t_prev = $time;
      seen[63-i] = mdio_o;
      oes[63-i]  = mdio_oe;
      @(negedge mdc);
      if (rd && i + 1 == 47) mdio_i = ta_ok ? 1'b0 : 1'b1;
      else if (rd && i + 1 >= 48 && i + 1 <= 63) mdio_i = resp[62-i];
      else mdio_i = 1'b1;
      if (interfere && i == 10) begin
        @(negedge clk); reg_wdata = {16'hDEAD, 5'd7, 5'd7, 6'b000010}; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
      end
    end
    t_dur = $time - t0;
    mdio_i = 1'b1;
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] cmd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (cmd[1] ? 2'b10 : 2'b01), phy, ra, 2'b10, wd};
  endfunction

  task automatic op_and_check(input logic [44:0] v, input bit interfere, input string tag);
    logic [1:0] cmd; logic [4:0] phy, ra; logic [15:0] wd, resp; bit ta_ok, rd;
    logic [63:0] seen, oes, ef, eoe;
    longint tr, tp, td;
    logic [31:0] erd;
    {cmd, phy, ra, wd, resp, ta_ok} = v;
    rd = cmd[1];
    run_op(cmd, phy, ra, wd, resp, ta_ok, interfere, seen, oes, tr, tp, td);
    ef  = exp_frame(cmd, phy, ra, wd);
    eoe = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    chk(oes == eoe, rd ? "R7 read output enable" : "R6 write output enable", oes, eoe);
    chk((seen & eoe) == (ef & eoe), "R6 frame bits", seen & eoe, ef & eoe);
    chk(tr == longint'(DIV * TCK), "R5 first mdc rise", 64'(tr), 64'(DIV * TCK));
    chk(tp == longint'(2 * DIV * TCK), "R5 mdc period", 64'(tp), 64'(2 * DIV * TCK));
    chk(td == longint'(128 * DIV * TCK), "R10 frame duration", 64'(td), 64'(128 * DIV * TCK));
    @(negedge clk);
    erd = {(rd ? resp : wd), phy, ra, 2'b00, (rd & ~ta_ok), 1'b0, 2'b00};
    chk(reg_rdata == erd, rd ? "R8 R9 read result" : "R2 write result", 64'(reg_rdata), 64'(erd));
    chk(mdc == 1'b0, "R5 mdc idle low", 64'(mdc), 64'd0);
    if (tag.len() > 0) $display("done %s", tag);
  endtask

  initial begin
    #(200_000 * TCK);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reg_rdata == {16'h0, DEFP, 11'h0}, "R1 reset register", 64'(reg_rdata), 64'({16'h0, DEFP, 11'h0}));
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset pins", {62'b0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(reg_rdata == {16'h0, DEFP, 11'h0}, "R1 after release", 64'(reg_rdata), 64'({16'h0, DEFP, 11'h0}));

    // R2 field-only write starts nothing
    reg_write({16'hBEEF, 5'd9, 5'd3, 6'b111100});
    chk(reg_rdata == {16'hBEEF, 5'd9, 5'd3, 6'b0}, "R2 field write", 64'(reg_rdata), 64'({16'hBEEF, 5'd9, 5'd3, 6'b0}));
    repeat (3 * DIV) @(negedge clk);
    chk(reg_rdata[2] == 1'b0 && mdc == 1'b0, "R2 no operation", {62'b0, reg_rdata[2], mdc}, 64'd0);

    // table walk: R3 R6 R7 R8 R9 R10
    for (int k = 0; k < 6; k++) op_and_check(VEC[k], 1'b0, "");

    // R4: write while busy is ignored (write injected mid frame)
    op_and_check({2'd1, 5'd12, 5'd5, 16'hC0DE, 16'h0, 1'b1}, 1'b1, "");
    repeat (2 * DIV) @(negedge clk);
    chk(reg_rdata[31:6] == {16'hC0DE, 5'd12, 5'd5}, "R4 busy write ignored",
        64'(reg_rdata[31:6]), 64'({16'hC0DE, 5'd12, 5'd5}));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule